// File: doc/BRIEF.md
# Program Counter Stack Sequencer

This block saves and restores the program counter on a memory stack that grows toward lower addresses. It carries out three fixed three-step sequences. An interrupt entry pushes the current PC and loads a fixed service-routine address. A subroutine call pushes the PC and loads a supplied target. A return pops the saved PC back. The block holds its own PC, stack pointer, memory address register and memory buffer register. It drives a single-port memory interface for the stack.

Interrupt requests are accepted only at an instruction boundary, which is marked by `instrDone`. They are also accepted only while interrupts are not masked. Taking an interrupt masks further requests automatically, and a pulse on `intEnable` unmasks them. `done` pulses once when a sequence has finished.

Top module: `stack_seq`

## Requirements
- R1: After reset, pcOut equals RESET_PC, spOut equals SP_TOP, intDisabled is 0, busy is 0, done is 0, and memWe and memRe are 0.
- R2: An accepted interrupt writes the PC held at acceptance to memory at the old SP. SP then drops by one, and pcOut becomes ISR_ADDR.
- R3: A call writes the PC held at acceptance to memory at the old SP. SP then drops by one, and pcOut becomes the callTarget sampled in the acceptance cycle.
- R4: A return first raises SP by one. It then reads memory at the new SP, and pcOut takes the word read.
- R5: Accepting an interrupt sets intDisabled. A one-cycle intEnable pulse while idle clears it.
- R6: An interrupt request is ignored while intDisabled is 1. busy stays 0 and pcOut is unchanged.
- R7: An interrupt request is ignored while instrDone is 0.
- R8: When several starts are valid in the same idle cycle, an interrupt wins over a call, and a call wins over a return.
- R9: Start inputs are ignored while busy is 1. They neither extend nor restart the running sequence.
- R10: busy is 1 for exactly three cycles after the accepting edge. memWe is 1 only in the third of those cycles, with memAddr equal to spOut. done is 1 for exactly the one cycle that follows.
- R11: Nested calls followed by the same number of returns restore each pushed PC in last-in, first-out order. SP returns to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqReq | input | 1 | Interrupt request level |
| instrDone | input | 1 | High at an instruction boundary |
| intEnable | input | 1 | Clears the interrupt mask |
| callStart | input | 1 | Starts a call sequence |
| callTarget | input | AW | Call destination address |
| retStart | input | 1 | Starts a return sequence |
| memRdData | input | AW | Read data, valid the cycle after memAddr is loaded |
| memAddr | output | AW | Stack memory address (MAR) |
| memWrData | output | AW | Stack write data (MBR) |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| pcOut | output | AW | Program counter |
| spOut | output | AW | Stack pointer |
| intDisabled | output | 1 | Interrupt mask flag |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the points where an off-by-one stack pointer would go unnoticed. It checks that pushes land at the old SP and that a return reads the slot above, and it pairs nested calls with returns. A design that swapped the increment and the address load would return the wrong PC. It also fires simultaneous starts and starts during a running sequence. A wrong priority or a missing busy guard shows up as the wrong final PC or an extra push. Masked requests and requests outside an instruction boundary are checked to leave busy low and the PC untouched.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_T0, ST_T1, ST_T2} seq_state_t;
  typedef enum logic [1:0] {OP_IRQ, OP_CALL, OP_RET} seq_op_t;

  typedef struct packed {
    logic mbrFromPc;
    logic marFromSp;
    logic pcFromVec;
    logic pcFromTgt;
    logic pcFromMem;
    logic spInc;
    logic spDec;
    logic memWr;
    logic memRd;
  } seq_strobe_t;

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        irqReq,
  input  logic        instrDone,
  input  logic        intEnable,
  input  logic        callStart,
  input  logic        retStart,
  output seq_strobe_t strb,
  output logic        loadTarget,
  output logic        busy,
  output logic        done,
  output logic        intDisabled
);

  seq_state_t state;
  seq_op_t    opQ;
  seq_op_t    opSel;
  logic       irqOk;
  logic       go;
  logic       isPush;

  // Acceptance only in idle; fixed priority irq > call > ret
  always_comb begin
    irqOk = irqReq && instrDone && !intDisabled;
    go    = (state == ST_IDLE) && (irqOk || callStart || retStart);
    if (irqOk)          opSel = OP_IRQ;
    else if (callStart) opSel = OP_CALL;
    else                opSel = OP_RET;
    loadTarget = go && (opSel == OP_CALL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      opQ         <= OP_RET;
      done        <= 1'b0;
      intDisabled <= 1'b0;
    end else begin
      done <= (state == ST_T2);
      case (state)
        ST_IDLE: if (go) begin
          state <= ST_T0;
          opQ   <= opSel;
        end
        ST_T0:   state <= ST_T1;
        ST_T1:   state <= ST_T2;
        default: state <= ST_IDLE;
      endcase
      if (go && opSel == OP_IRQ) intDisabled <= 1'b1;
      else if (intEnable)        intDisabled <= 1'b0;
    end
  end

  assign busy   = (state != ST_IDLE);
  assign isPush = (opQ != OP_RET);

  // Microstep strobes per state and operation
  always_comb begin
    strb = '0;
    case (state)
      ST_T0: begin
        strb.mbrFromPc = isPush;
        strb.spInc     = !isPush;
      end
      ST_T1: begin
        strb.marFromSp = 1'b1;
        strb.pcFromVec = (opQ == OP_IRQ);
        strb.pcFromTgt = (opQ == OP_CALL);
      end
      ST_T2: begin
        strb.memWr     = isPush;
        strb.spDec     = isPush;
        strb.memRd     = !isPush;
        strb.pcFromMem = !isPush;
      end
      default: strb = '0;
    endcase
  end

endmodule

// File: rtl/stack_seq_dp.sv
module stack_seq_dp
  import stack_seq_pkg::*;
#(
  parameter int              AW       = 8,
  parameter logic [AW-1:0]   SP_TOP   = '1,
  parameter logic [AW-1:0]   ISR_ADDR = '0,
  parameter logic [AW-1:0]   RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  seq_strobe_t   strb,
  input  logic          loadTarget,
  input  logic [AW-1:0] callTarget,
  input  logic [AW-1:0] memRdData,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] mar,
  output logic [AW-1:0] mbr
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] targetQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= RESET_PC;
      sp      <= SP_TOP;
      mar     <= '0;
      mbr     <= '0;
      targetQ <= '0;
    end else begin
      if (loadTarget)     targetQ <= callTarget;
      if (strb.mbrFromPc) mbr <= pc;
      if (strb.marFromSp) mar <= sp;
      if (strb.spInc)     sp  <= sp + ONE;
      else if (strb.spDec) sp <= sp - ONE;
      if (strb.pcFromVec)      pc <= ISR_ADDR;
      else if (strb.pcFromTgt) pc <= targetQ;
      else if (strb.pcFromMem) pc <= memRdData;
    end
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int            AW       = 8,
  parameter logic [AW-1:0] SP_TOP   = 8'hF0,
  parameter logic [AW-1:0] ISR_ADDR = 8'h40,
  parameter logic [AW-1:0] RESET_PC = 8'h10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          irqReq,
  input  logic          instrDone,
  input  logic          intEnable,
  input  logic          callStart,
  input  logic [AW-1:0] callTarget,
  input  logic          retStart,
  input  logic [AW-1:0] memRdData,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] memWrData,
  output logic          memWe,
  output logic          memRe,
  output logic [AW-1:0] pcOut,
  output logic [AW-1:0] spOut,
  output logic          intDisabled,
  output logic          busy,
  output logic          done
);

  seq_strobe_t strb;
  logic        loadTarget;

  stack_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .instrDone(instrDone),
    .intEnable(intEnable), .callStart(callStart), .retStart(retStart),
    .strb(strb), .loadTarget(loadTarget), .busy(busy), .done(done),
    .intDisabled(intDisabled)
  );

  stack_seq_dp #(.AW(AW), .SP_TOP(SP_TOP), .ISR_ADDR(ISR_ADDR), .RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadTarget(loadTarget),
    .callTarget(callTarget), .memRdData(memRdData),
    .pc(pcOut), .sp(spOut), .mar(memAddr), .mbr(memWrData)
  );

  assign memWe = strb.memWr;
  assign memRe = strb.memRd;

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          irqReq,
  input logic          instrDone,
  input logic          intEnable,
  input logic [AW-1:0] memAddr,
  input logic          memWe,
  input logic          memRe,
  input logic [AW-1:0] spOut,
  input logic          intDisabled,
  input logic          busy,
  input logic          done
);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));

  assert_push_at_sp_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr == spOut) && busy);

  assert_push_decrements_R2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> spOut == $past(spOut) - AW'(1));

  assert_rw_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  assert_mask_set_by_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intDisabled) |-> $past(irqReq && instrDone && !busy));

  assert_mask_clear_by_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intDisabled) |-> $past(intEnable));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

endmodule

bind stack_seq stack_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .instrDone(instrDone),
  .intEnable(intEnable), .memAddr(memAddr), .memWe(memWe), .memRe(memRe),
  .spOut(spOut), .intDisabled(intDisabled), .busy(busy), .done(done)
);

// File: tb/tb_stack_seq.sv
module tb_stack_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          irqReq = 1'b0, instrDone = 1'b1, intEnable = 1'b0;
  logic          callStart = 1'b0, retStart = 1'b0;
  logic [AW-1:0] callTarget = '0;
  logic [AW-1:0] memRdData, memAddr, memWrData, pcOut, spOut;
  logic          memWe, memRe, intDisabled, busy, done;
  logic [AW-1:0] mem [0:255];

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_seq dut (.*);

  always_ff @(posedge clk) if (memWe) mem[memAddr] <= memWrData;
  assign memRdData = mem[memAddr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit irq, input bit call, input logic [AW-1:0] tgt, input bit ret);
    irqReq = irq; callStart = call; callTarget = tgt; retStart = ret;
    @(negedge clk);
    irqReq = 0; callStart = 0; retStart = 0; callTarget = '0;
  endtask

  // Runs a push (call) and checks timing, memory and SP. R3, R10.
  task automatic doCall(input logic [AW-1:0] tgt);
    logic [AW-1:0] pc0, sp0;
    pc0 = pcOut; sp0 = spOut;
    issue(0, 1, tgt, 0);
    check(busy == 1 && memWe == 0, "R10", busy, 1);
    @(negedge clk);
    @(negedge clk);
    check(memWe && memAddr == sp0 && memWrData == pc0, "R10", memWrData, pc0);
    @(negedge clk);
    check(done && !busy, "R10", done, 1);
    check(pcOut == tgt, "R3", pcOut, tgt);
    check(spOut == sp0 - 1, "R3", spOut, sp0 - 1);
    check(mem[sp0] == pc0, "R3", mem[sp0], pc0);
    @(negedge clk);
    check(!done, "R10", done, 0);
  endtask

  // R4: return pops from SP+1
  task automatic doRet(input logic [AW-1:0] expPc);
    logic [AW-1:0] sp0;
    sp0 = spOut;
    issue(0, 0, '0, 1);
    repeat (3) @(negedge clk);
    check(done, "R4", done, 1);
    check(pcOut == expPc, "R4", pcOut, expPc);
    check(spOut == sp0 + 1, "R4", spOut, sp0 + 1);
    @(negedge clk);
  endtask

  task automatic testReset;
    check(pcOut == 8'h10 && spOut == 8'hF0, "R1", pcOut, 8'h10);
    check(!intDisabled && !busy && !done && !memWe && !memRe, "R1", busy, 0);
  endtask

  task automatic testNested;
    doCall(8'h22);
    doCall(8'h33);
    check(mem[8'hEF] == 8'h22, "R11", mem[8'hEF], 8'h22);
    doRet(8'h22);
    doRet(8'h10);
    check(spOut == 8'hF0, "R11", spOut, 8'hF0);
  endtask

  task automatic testIrqGating;
    instrDone = 0;
    issue(1, 0, '0, 0);
    instrDone = 1;
    check(!busy && pcOut == 8'h10, "R7", busy, 0);
    @(negedge clk);
    issue(1, 0, '0, 0);
    check(busy && intDisabled, "R5", intDisabled, 1);
    repeat (3) @(negedge clk);
    check(pcOut == 8'h40 && spOut == 8'hEF, "R2", pcOut, 8'h40);
    check(mem[8'hF0] == 8'h10, "R2", mem[8'hF0], 8'h10);
    issue(1, 0, '0, 0);
    check(!busy && pcOut == 8'h40, "R6", busy, 0);
    @(negedge clk);
    check(!busy && spOut == 8'hEF, "R6", spOut, 8'hEF);
    intEnable = 1;
    @(negedge clk);
    intEnable = 0;
    check(!intDisabled, "R5", intDisabled, 0);
    doRet(8'h10);
  endtask

  task automatic testPriority;
    issue(1, 1, 8'h55, 1);
    repeat (3) @(negedge clk);
    check(pcOut == 8'h40 && spOut == 8'hEF, "R8", pcOut, 8'h40);
    intEnable = 1;
    @(negedge clk);
    intEnable = 0;
    issue(0, 1, 8'h55, 1);
    repeat (3) @(negedge clk);
    check(pcOut == 8'h55 && spOut == 8'hEE, "R8", pcOut, 8'h55);
    check(mem[8'hEF] == 8'h40, "R8", mem[8'hEF], 8'h40);
    @(negedge clk);
  endtask

  task automatic testBusyIgnore;
    issue(0, 1, 8'h66, 0);
    issue(1, 1, 8'h77, 1);
    repeat (2) @(negedge clk);
    check(pcOut == 8'h66 && spOut == 8'hED, "R9", pcOut, 8'h66);
    @(negedge clk);
    check(!busy && !done, "R9", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testNested();
    testIrqGating();
    testPriority();
    testBusyIgnore();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule